// File: doc/BRIEF.md
# Multi-slice edge timestamping engine

The engine watches a bus of input lines split into slices of 32. Each line passes through a two-flop synchroniser. When one or more enabled lines of a slice change, the slice captures the value of a free-running 64-bit tick counter together with two 32-bit snapshots of that slice: the value before the change and the value after it. Because the "after" snapshot carries only the changes on enabled lines, software XORs the two snapshots to get exactly the set of lines that moved at that tick. A global line number is the slice index times 32 plus the bit index. The tick counter advances once every `TICK_DIV` clocks. With the default of 8 at 250 MHz this is a 32 ns tick, so software turns ticks into nanoseconds with a left shift by 5.

Captured slices wait in one-entry holding registers. A collector state machine moves them into an event FIFO, one slice per cycle and lowest slice first. The machine has three states. ST_OFF is entered whenever the engine enable is low. ST_OFF goes to ST_WATCH once the engine is enabled. ST_WATCH goes to ST_MOVE when any slice is holding an event. ST_MOVE pushes the lowest holding slice each cycle, and returns to ST_WATCH when no other slice is still holding an event.

Software uses a 32-bit register bus with a combinational read and a single-cycle write strobe. It reads the FIFO head through a set of registers and pops the head with a command write. A level interrupt reports when the FIFO holds at least a programmed number of entries.

Top module: `edge_stamp_engine`

## Requirements
- R1: The timestamp is a 64-bit counter that advances by one every TICK_DIV clocks (default 8). Two events whose line changes occur 80 clocks apart carry timestamps that differ by exactly 10.
- R2: A change on an enabled line pushes one entry. The head timestamp is read at 0x04 (upper word) and 0x08 (lower word). The slice number is in bits 23:16 of the source register at 0x0C. The "after" snapshot is at 0x10 and the "before" snapshot is at 0x14.
- R3: Changes on lines whose enable bit is 0 produce no entry. A later entry's "before" snapshot still shows their current level, and they never appear in the XOR of the two snapshots.
- R4: All enabled lines of one slice that change in the same cycle produce a single entry. Its XOR holds every one of those bits.
- R5: When several slices change in the same cycle, each produces its own entry. The entries are queued in ascending slice order and all carry the same timestamp.
- R6: The status register at 0x20 gives the FIFO occupancy in bits 15:8. Writing a value with bit 0 set to the command register at 0x1C pops the head and lowers the occupancy by one.
- R7: While the FIFO holds FIFO_DEPTH entries (default 16), new events are dropped and the sticky overflow flag in status bit 0 is set. Writing a value with bit 1 set to the command register clears the flag.
- R8: The interrupt output is high exactly while control bit 1 (interrupt enable) is set and the occupancy is at least the threshold held in control bits 15:8.
- R9: While control bit 0 (engine enable) is 0, no entries are captured. Line changes made while the engine is disabled are not reported after it is enabled again.
- R10: Each slice s has an enable mask at byte offset 0x40 + 0x20*s. Bit n enables line n of that slice. The masks are read and written independently of one another.
- R11: After reset, the control register reads 0x100 (engine off, interrupt off, threshold 1), the status register reads 0, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_i | input | N_SLICES*32 | Monitored lines; slice s occupies bits 32*s+31:32*s |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
Each kind of internal fault shows up at the ports in its own way:
- A stale "before" register in a slice gives an XOR that differs from the lines actually toggled, on the very next entry of that slice.
- A collector stuck in ST_WATCH or ST_MOVE leaves the occupancy in bits 15:8 at zero, or shows it counting beyond the events made, within a few clocks of the change.
- A wrong FIFO pointer or count shows up as entries popped out of order, or as an occupancy that does not fall by one per pop, on the next status read.
- A wrong tick prescaler shows up only as a timestamp difference between two events spaced a known number of clocks apart.

// File: rtl/ese_pkg.sv
package ese_pkg;
    localparam int SLICE_LINES = 32;
    localparam int TS_W        = 64;

    // bus byte offsets
    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_TS_HI   = 'h04;
    localparam int OFS_TS_LO   = 'h08;
    localparam int OFS_SRC     = 'h0C;
    localparam int OFS_CUR     = 'h10;
    localparam int OFS_PREV    = 'h14;
    localparam int OFS_CMD     = 'h1C;
    localparam int OFS_STAT    = 'h20;
    localparam int OFS_MASK0   = 'h40;
    localparam int MASK_STRIDE = 'h20;

    typedef struct packed {
        logic [TS_W-1:0]        ts;
        logic [7:0]             slice;
        logic [SLICE_LINES-1:0] prev;
        logic [SLICE_LINES-1:0] cur;
    } ese_entry_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_MOVE  = 2'd2
    } ese_state_t;
endpackage

// File: rtl/ese_slice_watch.sv
module ese_slice_watch import ese_pkg::*; #(
    parameter int IDX = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLICE_LINES-1:0] lines_i,
    input  logic [SLICE_LINES-1:0] mask_i,
    input  logic                   run_i,
    input  logic [TS_W-1:0]        ts_i,
    input  logic                   grant_i,
    output logic                   pend_o,
    output ese_entry_t             ent_o,
    output logic                   overrun_o
);
    logic [SLICE_LINES-1:0] sync_a, sync_b, last_q, moved;
    logic                   any_move;

    assign moved    = (sync_b ^ last_q) & mask_i;
    assign any_move = run_i && (moved != '0);
    assign overrun_o = any_move && pend_o && !grant_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            last_q <= '0;
        end else begin
            sync_a <= lines_i;
            sync_b <= sync_a;
            last_q <= sync_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            ent_o  <= '0;
        end else if (!run_i) begin
            pend_o <= 1'b0;
        end else if (any_move && (!pend_o || grant_i)) begin
            pend_o     <= 1'b1;
            ent_o.ts   <= ts_i;
            ent_o.slice <= 8'(IDX);
            ent_o.prev <= last_q;
            ent_o.cur  <= (sync_b & mask_i) | (last_q & ~mask_i);
        end else if (grant_i) begin
            pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/ese_event_fifo.sv
module ese_event_fifo import ese_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  ese_entry_t                   data_i,
    input  logic                         pop_i,
    output ese_entry_t                   head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         drop_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    ese_entry_t     mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic           do_push, do_pop;

    assign do_pop  = pop_i && (count_o != '0);
    assign do_push = push_i && (count_o != CW'(DEPTH));
    assign drop_o  = push_i && (count_o == CW'(DEPTH));
    assign head_o  = (count_o != '0) ? mem[rd_ptr] : '0;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count_o <= count_o + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/ese_collect.sv
module ese_collect import ese_pkg::*; #(
    parameter int N = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic [N-1:0]         pend_i,
    input  ese_entry_t [N-1:0]   ent_i,
    output logic                 push_o,
    output ese_entry_t           ent_o,
    output logic [N-1:0]         grant_o
);
    ese_state_t   state_q, state_d;
    logic [N-1:0] pick;

    // lowest holding slice
    always_comb begin
        pick = '0;
        for (int s = N-1; s >= 0; s--) begin
            if (pend_i[s]) pick = N'(1) << s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = run_i ? ST_WATCH : ST_OFF;
            ST_WATCH: begin
                if (!run_i)              state_d = ST_OFF;
                else if (pend_i != '0)   state_d = ST_MOVE;
            end
            ST_MOVE: begin
                if (!run_i)                       state_d = ST_OFF;
                else if ((pend_i & ~pick) == '0)  state_d = ST_WATCH;
            end
            default:  state_d = ST_OFF;
        endcase
    end

    always_comb begin
        push_o  = 1'b0;
        grant_o = '0;
        ent_o   = '0;
        if (state_q == ST_MOVE && run_i && pend_i != '0) begin
            push_o  = 1'b1;
            grant_o = pick;
            for (int s = 0; s < N; s++) begin
                if (pick[s]) ent_o = ent_i[s];
            end
        end
    end
endmodule

// File: rtl/edge_stamp_engine.sv
module edge_stamp_engine import ese_pkg::*; #(
    parameter int N_SLICES   = 3,
    parameter int FIFO_DEPTH = 16,
    parameter int TICK_DIV   = 8,
    parameter int ADDR_W     = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_SLICES*SLICE_LINES-1:0] lines_i,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_wr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    output logic                            irq_o
);
    localparam int CW = $clog2(FIFO_DEPTH+1);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic                    ctrl_en, ctrl_ie;
    logic [7:0]              ctrl_thr;
    logic [SLICE_LINES-1:0]  mask_q [N_SLICES];
    logic                    ovf_q;
    logic [PW-1:0]           pre_q;
    logic [TS_W-1:0]         ts_q;

    logic [N_SLICES-1:0]     pend, grant, overrun;
    ese_entry_t [N_SLICES-1:0] slice_ent;
    ese_entry_t              push_ent, head;
    logic                    fifo_push, fifo_drop;
    logic [CW-1:0]           fifo_cnt;
    logic                    cmd_pop, cmd_clr;

    function automatic logic [ADDR_W-1:0] mask_addr(input int s);
        return ADDR_W'(OFS_MASK0 + s * MASK_STRIDE);
    endfunction

    assign cmd_pop = bus_wr && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata[0];
    assign cmd_clr = bus_wr && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata[1];

    // tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            ts_q  <= '0;
        end else if (pre_q == PW'(TICK_DIV-1)) begin
            pre_q <= '0;
            ts_q  <= ts_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // control and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_ie  <= 1'b0;
            ctrl_thr <= 8'd1;
            for (int s = 0; s < N_SLICES; s++) mask_q[s] <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_CTRL)) begin
                ctrl_en  <= bus_wdata[0];
                ctrl_ie  <= bus_wdata[1];
                ctrl_thr <= bus_wdata[15:8];
            end
            for (int s = 0; s < N_SLICES; s++) begin
                if (bus_addr == mask_addr(s)) mask_q[s] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            ovf_q <= 1'b0;
        else if (fifo_drop || overrun != '0)   ovf_q <= 1'b1;
        else if (cmd_clr)                      ovf_q <= 1'b0;
    end

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        ese_slice_watch #(.IDX(s)) u_watch (
            .clk       (clk),
            .rst_n     (rst_n),
            .lines_i   (lines_i[s*SLICE_LINES +: SLICE_LINES]),
            .mask_i    (mask_q[s]),
            .run_i     (ctrl_en),
            .ts_i      (ts_q),
            .grant_i   (grant[s]),
            .pend_o    (pend[s]),
            .ent_o     (slice_ent[s]),
            .overrun_o (overrun[s])
        );
    end

    ese_collect #(.N(N_SLICES)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ctrl_en),
        .pend_i  (pend),
        .ent_i   (slice_ent),
        .push_o  (fifo_push),
        .ent_o   (push_ent),
        .grant_o (grant)
    );

    ese_event_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (fifo_push),
        .data_i  (push_ent),
        .pop_i   (cmd_pop),
        .head_o  (head),
        .count_o (fifo_cnt),
        .drop_o  (fifo_drop)
    );

    assign irq_o = ctrl_ie && (8'(fifo_cnt) >= ctrl_thr);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):  bus_rdata = {16'd0, ctrl_thr, 6'd0, ctrl_ie, ctrl_en};
            ADDR_W'(OFS_TS_HI): bus_rdata = head.ts[63:32];
            ADDR_W'(OFS_TS_LO): bus_rdata = head.ts[31:0];
            ADDR_W'(OFS_SRC):   bus_rdata = {8'd0, head.slice, 16'd0};
            ADDR_W'(OFS_CUR):   bus_rdata = head.cur;
            ADDR_W'(OFS_PREV):  bus_rdata = head.prev;
            ADDR_W'(OFS_STAT):  bus_rdata = {16'd0, 8'(fifo_cnt), 7'd0, ovf_q};
            default: begin
                for (int s = 0; s < N_SLICES; s++) begin
                    if (bus_addr == mask_addr(s)) bus_rdata = mask_q[s];
                end
            end
        endcase
    end
endmodule

// File: rtl/edge_stamp_checker.sv
module edge_stamp_checker #(
    parameter int DEPTH = 16,
    parameter int N     = 3,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          ie,
    input logic          irq,
    input logic [CW-1:0] occ,
    input logic          push,
    input logic          pop,
    input logic [N-1:0]  grant,
    input logic          ovf,
    input logic          ovf_clr
);
    a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r6_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && occ != '0) |=> (occ == $past(occ) - 1'b1));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    a_r9_off_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !push);

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie);
endmodule

bind edge_stamp_engine edge_stamp_checker #(
    .DEPTH(FIFO_DEPTH), .N(N_SLICES), .CW(CW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_en),
    .ie      (ctrl_ie),
    .irq     (irq_o),
    .occ     (fifo_cnt),
    .push    (fifo_push),
    .pop     (cmd_pop),
    .grant   (grant),
    .ovf     (ovf_q),
    .ovf_clr (cmd_clr)
);

// File: tb/edge_stamp_engine_tb_top.sv
`timescale 1ns/1ps
module edge_stamp_engine_tb_top;
    localparam int NS = 3;
    localparam int NL = NS * 32;
    localparam int DEPTH = 16;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lines = '0;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    always #2 clk = ~clk;

    edge_stamp_engine #(.N_SLICES(NS), .FIFO_DEPTH(DEPTH), .TICK_DIV(8), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .lines_i(lines), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

    typedef struct packed {
        logic [7:0]  sl;
        logic [31:0] pv;
        logic [31:0] cv;
    } exp_t;

    exp_t          exp_q[$];
    logic [63:0]   ts_q[$];
    logic [NL-1:0] line_m = '0;
    logic [31:0]   mask_m [NS];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, expv);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    task automatic set_mask(input int s, input logic [31:0] m);
        bus_write('h40 + 'h20 * s, m);
        mask_m[s] = m;
    endtask

    // driver: predicts entries and pushes them to the scoreboard
    task automatic drive_lines(input logic [NL-1:0] nv, input bit keep);
        for (int s = 0; s < NS; s++) begin
            logic [31:0] o, n, m;
            o = line_m[s*32 +: 32];
            n = nv[s*32 +: 32];
            m = mask_m[s];
            if (((o ^ n) & m) != 0 && keep)
                exp_q.push_back('{8'(s), o, (n & m) | (o & ~m)});
        end
        @(negedge clk);
        lines = nv;
        line_m = nv;
        repeat (8) @(negedge clk);
    endtask

    // monitor: drains the FIFO and compares against the scoreboard
    task automatic drain(input string tag);
        logic [31:0] st, hi, lo, src, cur, prv;
        logic [7:0]  occ;
        exp_t e;
        bus_read('h20, st);
        occ = st[15:8];
        while (occ != 0) begin
            bus_read('h04, hi);
            bus_read('h08, lo);
            bus_read('h0C, src);
            bus_read('h10, cur);
            bus_read('h14, prv);
            if (exp_q.size() == 0) begin
                check({tag, " unexpected entry"}, 1, 0);
            end else begin
                e = exp_q.pop_front();
                check({tag, " slice"}, src[23:16], e.sl);
                check({tag, " after"}, cur, e.cv);
                check({tag, " before"}, prv, e.pv);
            end
            ts_q.push_back({hi, lo});
            bus_write('h1C, 32'h1);
            bus_read('h20, st);
            check("R6 pop lowers occupancy", st[15:8], occ - 8'd1);
            occ = st[15:8];
        end
        check({tag, " all predicted entries seen"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [NL-1:0] v;
        for (int s = 0; s < NS; s++) mask_m[s] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        bus_read('h00, d); check("R11 ctrl", d, 32'h100);
        bus_read('h20, d); check("R11 status", d, 0);
        check("R11 irq", irq, 0);

        // R10 per-slice masks
        set_mask(0, 32'h0000_FFFF);
        set_mask(1, 32'hFFFF_FFFF);
        set_mask(2, 32'hFFFF_FFFF);
        bus_read('h40, d); check("R10 mask slice0", d, 32'h0000_FFFF);
        bus_read('h60, d); check("R10 mask slice1", d, 32'hFFFF_FFFF);
        set_mask(2, 32'h8000_0081);
        bus_read('h80, d); check("R10 mask slice2", d, 32'h8000_0081);
        bus_read('h40, d); check("R10 mask slice0 untouched", d, 32'h0000_FFFF);

        bus_write('h00, 32'h103);

        // R2 single line
        v = line_m; v[32 + 5] = 1'b1;
        drive_lines(v, 1);
        check("R8 irq at threshold 1", irq, 1);
        drain("R2");
        check("R8 irq after drain", irq, 0);

        // R3 masked line
        v = line_m; v[20] = 1'b1;
        drive_lines(v, 1);
        bus_read('h20, d); check("R3 masked change no entry", d[15:8], 0);
        check("R3 irq stays low", irq, 0);
        v = line_m; v[3] = 1'b1;
        drive_lines(v, 1);
        drain("R3");

        // R4 several lines of one slice at once
        v = line_m; v[64 + 0] = 1'b1; v[64 + 7] = 1'b1; v[64 + 31] = 1'b1; v[64 + 4] = 1'b1;
        drive_lines(v, 1);
        bus_read('h20, d); check("R4 one entry", d[15:8], 1);
        drain("R4");

        // R5 two slices at once
        ts_q.delete();
        v = line_m; v[32 + 9] = 1'b1; v[64 + 0] = 1'b0;
        drive_lines(v, 1);
        drain("R5");
        check("R5 two entries", ts_q.size(), 2);
        if (ts_q.size() == 2) check("R5 shared timestamp", ts_q[1], ts_q[0]);

        // R1 tick spacing
        ts_q.delete();
        v = line_m; v[32 + 1] = 1'b1;
        drive_lines(v, 1);
        repeat (71) @(negedge clk);
        v = line_m; v[32 + 1] = 1'b0;
        drive_lines(v, 1);
        drain("R1");
        if (ts_q.size() == 2) check("R1 tick difference", ts_q[1] - ts_q[0], 10);
        else check("R1 entry count", ts_q.size(), 2);

        // R8 threshold 3
        bus_write('h00, 32'h303);
        for (int i = 0; i < 2; i++) begin
            v = line_m; v[32 + 2] = ~v[32 + 2];
            drive_lines(v, 1);
        end
        check("R8 below threshold", irq, 0);
        v = line_m; v[32 + 2] = ~v[32 + 2];
        drive_lines(v, 1);
        check("R8 at threshold", irq, 1);
        drain("R8");
        check("R8 low after drain", irq, 0);

        // R7 overflow
        bus_write('h00, 32'h101);
        for (int i = 0; i < DEPTH + 1; i++) begin
            v = line_m; v[32] = ~v[32];
            drive_lines(v, i < DEPTH);
        end
        bus_read('h20, d); check("R7 full with overflow", d, 32'h1001);
        drain("R7");
        bus_read('h20, d); check("R7 overflow sticky", d, 32'h1);
        bus_write('h1C, 32'h2);
        bus_read('h20, d); check("R7 overflow cleared", d, 0);

        // R9 engine off
        bus_write('h00, 32'h0);
        v = line_m; v[32 + 12] = 1'b1;
        drive_lines(v, 0);
        bus_read('h20, d); check("R9 no capture while off", d, 0);
        bus_write('h00, 32'h103);
        repeat (8) @(negedge clk);
        bus_read('h20, d); check("R9 no late report", d, 0);
        v = line_m; v[32 + 13] = 1'b1;
        drive_lines(v, 1);
        drain("R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule